// File: doc/BRIEF.md
# Indexed USB Endpoint FIFO Bank

This block holds the packet buffers of seven USB device endpoints and lets a CPU reach all of them through one small set of windowed registers. A select register names the active endpoint. The data, count, status and control windows then refer to that endpoint alone. Endpoint 0 owns an 8-byte buffer. Endpoints 1 to 6 own 64-byte buffers. Bulk and interrupt traffic use the same path.

Data flows in two directions:
- **OUT endpoints.** The serial engine writes a received packet byte by byte through the receive port. A good-packet strobe at the end of the packet commits it, and the CPU then drains the bytes through the data window.
- **IN endpoints.** The CPU fills the buffer through the data window. The transmit port then streams the bytes out and resets the buffer when the transfer is done.

Every endpoint keeps its own pointer. The CPU can therefore move between endpoints and come back to the same place. The byte counter is loaded only by a committed packet and never by CPU traffic.

Top module: `usb_epbank`

## Requirements
- R1: Register offsets are: 0 select, 1 data, 2 count low, 3 count high, 4 status, 5 control, and 6 and 7 read as zero. The select register resets to 0 and stores bit field [2:0] of the written value. While it holds 7, a data read returns 0, a data write is ignored, and the count, status and control windows read 0.
- R2: On an OUT endpoint (control bit 0 = 0), a read of the data window returns the byte at that endpoint's pointer in the same cycle, and the pointer advances by one at the clock edge.
- R3: On an IN endpoint (control bit 0 = 1), a write of the data window stores the byte at that endpoint's pointer and advances the pointer by one, so writes may follow back to back.
- R4: A data write made when the pointer already equals the buffer size (8 for endpoint 0, 64 for the others) is dropped and sets the sticky overflow flag, status bit 0. A data read made when the pointer is not below the byte count returns 0 and leaves the pointer where it is.
- R5: The count-low window returns the endpoint's byte count. The count-high window reads 0.
- R6: Data-window reads and writes never change any byte count.
- R7: Received bytes are stored in order into the endpoint named on the receive port. Bytes beyond the buffer size are dropped. The good strobe loads the byte count with the number of stored bytes, resets the pointer and clears overflow. The bad strobe discards the packet and changes neither the count nor the pointer; it takes priority over the good strobe.
- R8: Each endpoint's pointer is independent. Selecting another endpoint and returning resumes at the same buffer position.
- R9: The transmit port works as follows:
  - tx_len shows the pointer of the endpoint named by tx_ep.
  - tx_data shows that endpoint's byte at a transmit index that starts at 0 and advances on each tx_rd.
  - tx_done resets that endpoint's pointer, its overflow flag and the transmit index.
- R10: Control bit 0 sets the direction and resets to OUT. A data read on an IN endpoint returns 0 without moving the pointer. A data write on an OUT endpoint is ignored.
- R11: After reset, every pointer, count, overflow flag and direction bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (advances the data pointer) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read |
| rx_wr | input | 1 | Received byte valid |
| rx_ep | input | 3 | Endpoint receiving the packet |
| rx_data | input | 8 | Received byte |
| rx_good | input | 1 | Packet ended and is valid: commit |
| rx_bad | input | 1 | Packet ended and is bad: discard |
| tx_ep | input | 3 | Endpoint being transmitted |
| tx_rd | input | 1 | Advance the transmit index |
| tx_done | input | 1 | Transmit finished: reset the endpoint |
| tx_data | output | 8 | Byte at the transmit index |
| tx_len | output | 7 | Number of bytes the CPU has loaded into the endpoint |

## Verification
The checker watches several rules on every cycle:
- The byte counts move only in a cycle after a good strobe.
- No pointer or count ever exceeds its endpoint's buffer size.
- The overflow flag holds until a commit or a transmit completion.
- A commit leaves the endpoint's pointer at zero.
- The count-high window always reads zero.
- A read past the stored length returns zero.

Some properties can only be shown by the bench's scenarios, which compare the ports against a reference model:
- byte ordering through the data window and the transmit port;
- pointers resuming after the select register moves away and back;
- discarded packets;
- writes and reads ignored because of direction or an invalid select.

// File: rtl/usb_epbank_pkg.sv
package usb_epbank_pkg;
  localparam int NEP_DEF   = 7;
  localparam int EP0_DEF   = 8;
  localparam int EPN_DEF   = 64;
  localparam int DW_DEF    = 8;
  localparam int EW_DEF    = 3;
  localparam int AW        = 3;

  localparam logic [AW-1:0] OFS_SEL  = 3'd0;
  localparam logic [AW-1:0] OFS_DATA = 3'd1;
  localparam logic [AW-1:0] OFS_CNTL = 3'd2;
  localparam logic [AW-1:0] OFS_CNTH = 3'd3;
  localparam logic [AW-1:0] OFS_STAT = 3'd4;
  localparam logic [AW-1:0] OFS_CTRL = 3'd5;
endpackage

// File: rtl/usb_epbank_rstsync.sv
module usb_epbank_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/usb_ep_rxfill.sv
module usb_ep_rxfill #(
  parameter int NEP       = 7,
  parameter int EP0_DEPTH = 8,
  parameter int EPN_DEPTH = 64,
  parameter int CW        = 7,
  parameter int EW        = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_wr,
  input  logic [EW-1:0]  rx_ep,
  input  logic           rx_good,
  input  logic           rx_bad,
  output logic [NEP-1:0] wr_en,
  output logic [CW-1:0]  wr_idx,
  output logic [NEP-1:0] commit,
  output logic [CW-1:0]  commit_len
);
  localparam logic [CW-1:0] LIM0 = CW'(EP0_DEPTH);
  localparam logic [CW-1:0] LIMN = CW'(EPN_DEPTH);

  logic [CW-1:0] fill_q, fill_d;
  logic [CW-1:0] limit;
  logic          ep_ok;
  logic          fill_en;

  assign ep_ok   = int'(rx_ep) < NEP;
  assign limit   = (rx_ep == '0) ? LIM0 : LIMN;
  assign fill_en = rx_wr | rx_good | rx_bad;

  always_comb begin
    fill_d = fill_q;
    wr_en  = '0;
    commit = '0;
    if (rx_bad) begin
      fill_d = '0;
    end else if (rx_good) begin
      fill_d = '0;
      if (ep_ok) commit[rx_ep] = 1'b1;
    end else if (rx_wr && ep_ok && (fill_q < limit)) begin
      wr_en[rx_ep] = 1'b1;
      fill_d       = fill_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fill_q <= '0;
    else if (fill_en) fill_q <= fill_d;
  end

  assign wr_idx     = fill_q;
  assign commit_len = fill_q;
endmodule

// File: rtl/usb_ep_slot.sv
module usb_ep_slot #(
  parameter int DEPTH = 64,
  parameter int CW    = 7,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          dir_wr,
  input  logic          dir_val,
  input  logic          rx_wr,
  input  logic [CW-1:0] rx_idx,
  input  logic [DW-1:0] rx_data,
  input  logic          commit,
  input  logic [CW-1:0] commit_len,
  input  logic [CW-1:0] tx_idx,
  input  logic          tx_done,
  output logic [DW-1:0] cpu_rdata,
  output logic [DW-1:0] tx_data,
  output logic [CW-1:0] ptr,
  output logic [CW-1:0] cnt,
  output logic          ovf,
  output logic          dir
);
  localparam int            IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] ptr_q, ptr_d, cnt_q, cnt_d;
  logic          ovf_q, ovf_d, dir_q, dir_d;
  logic          rd_ok, wr_take, wr_over, st_en;

  assign rd_ok   = !dir_q && (ptr_q < cnt_q);
  assign wr_take = cpu_wr && dir_q && (ptr_q < DEPTH_C);
  assign wr_over = cpu_wr && dir_q && (ptr_q >= DEPTH_C);
  assign st_en   = commit | tx_done | cpu_rd | cpu_wr | dir_wr;

  // storage: receive side wins a same-cycle collision
  always_ff @(posedge clk) begin
    if (rx_wr)        mem[rx_idx[IW-1:0]] <= rx_data;
    else if (wr_take) mem[ptr_q[IW-1:0]]  <= cpu_wdata;
  end

  always_comb begin
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    dir_d = dir_q;
    if (dir_wr) dir_d = dir_val;
    if (commit) begin
      cnt_d = commit_len;
      ptr_d = '0;
      ovf_d = 1'b0;
    end else if (tx_done) begin
      ptr_d = '0;
      ovf_d = 1'b0;
    end else begin
      if ((cpu_rd && rd_ok) || wr_take) ptr_d = ptr_q + CW'(1);
      if (wr_over) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      dir_q <= 1'b0;
    end else if (st_en) begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      dir_q <= dir_d;
    end
  end

  assign cpu_rdata = rd_ok ? mem[ptr_q[IW-1:0]] : '0;
  assign tx_data   = (tx_idx < DEPTH_C) ? mem[tx_idx[IW-1:0]] : '0;
  assign ptr       = ptr_q;
  assign cnt       = cnt_q;
  assign ovf       = ovf_q;
  assign dir       = dir_q;
endmodule

// File: rtl/usb_epbank.sv
module usb_epbank
  import usb_epbank_pkg::*;
#(
  parameter int NEP       = NEP_DEF,
  parameter int EP0_DEPTH = EP0_DEF,
  parameter int EPN_DEPTH = EPN_DEF,
  parameter int DW        = DW_DEF,
  parameter int EW        = EW_DEF,
  parameter int CW        = $clog2(EPN_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rx_wr,
  input  logic [EW-1:0] rx_ep,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_good,
  input  logic          rx_bad,
  input  logic [EW-1:0] tx_ep,
  input  logic          tx_rd,
  input  logic          tx_done,
  output logic [DW-1:0] tx_data,
  output logic [CW-1:0] tx_len
);
  localparam logic [CW-1:0] TXMAX = CW'(EPN_DEPTH);

  logic                    rst_sync_n;
  logic [EW-1:0]           sel_q, sel_d, sel_ix, tx_ix;
  logic                    sel_en, sel_ok, tx_ok;
  logic [CW-1:0]           tx_idx_q, tx_idx_d;
  logic                    tx_en;
  logic                    data_rd, data_wr, ctrl_wr;
  logic [NEP-1:0]          rx_wr_en, rx_commit;
  logic [CW-1:0]           rx_idx, rx_len;
  logic [NEP-1:0][CW-1:0]  ep_ptr, ep_cnt;
  logic [NEP-1:0]          ep_ovf, ep_dir;
  logic [NEP-1:0][DW-1:0]  ep_rdata, ep_txd;

  usb_epbank_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // register decode
  assign data_rd = bus_rd && (bus_addr == OFS_DATA) && sel_ok;
  assign data_wr = bus_wr && (bus_addr == OFS_DATA) && sel_ok;
  assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL) && sel_ok;
  assign sel_en  = bus_wr && (bus_addr == OFS_SEL);
  assign sel_d   = bus_wdata[EW-1:0];
  assign sel_ok  = int'(sel_q) < NEP;
  assign sel_ix  = sel_ok ? sel_q : '0;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  sel_q <= '0;
    else if (sel_en)  sel_q <= sel_d;
  end

  usb_ep_rxfill #(
    .NEP(NEP), .EP0_DEPTH(EP0_DEPTH), .EPN_DEPTH(EPN_DEPTH), .CW(CW), .EW(EW)
  ) u_fill (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rx_wr      (rx_wr),
    .rx_ep      (rx_ep),
    .rx_good    (rx_good),
    .rx_bad     (rx_bad),
    .wr_en      (rx_wr_en),
    .wr_idx     (rx_idx),
    .commit     (rx_commit),
    .commit_len (rx_len)
  );

  for (genvar i = 0; i < NEP; i++) begin : g_ep
    localparam int DEPTH = (i == 0) ? EP0_DEPTH : EPN_DEPTH;
    logic hit;
    assign hit = (sel_q == EW'(i));

    usb_ep_slot #(.DEPTH(DEPTH), .CW(CW), .DW(DW)) u_slot (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .cpu_rd     (data_rd && hit),
      .cpu_wr     (data_wr && hit),
      .cpu_wdata  (bus_wdata),
      .dir_wr     (ctrl_wr && hit),
      .dir_val    (bus_wdata[0]),
      .rx_wr      (rx_wr_en[i]),
      .rx_idx     (rx_idx),
      .rx_data    (rx_data),
      .commit     (rx_commit[i]),
      .commit_len (rx_len),
      .tx_idx     (tx_idx_q),
      .tx_done    (tx_done && (tx_ep == EW'(i))),
      .cpu_rdata  (ep_rdata[i]),
      .tx_data    (ep_txd[i]),
      .ptr        (ep_ptr[i]),
      .cnt        (ep_cnt[i]),
      .ovf        (ep_ovf[i]),
      .dir        (ep_dir[i])
    );
  end

  // transmit index
  assign tx_en = tx_done | tx_rd;
  always_comb begin
    tx_idx_d = tx_idx_q;
    if (tx_done)                   tx_idx_d = '0;
    else if (tx_idx_q < TXMAX)     tx_idx_d = tx_idx_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) tx_idx_q <= '0;
    else if (tx_en)  tx_idx_q <= tx_idx_d;
  end

  assign tx_ok   = int'(tx_ep) < NEP;
  assign tx_ix   = tx_ok ? tx_ep : '0;
  assign tx_data = tx_ok ? ep_txd[tx_ix] : '0;
  assign tx_len  = tx_ok ? ep_ptr[tx_ix] : '0;

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_SEL:  bus_rdata = DW'(sel_q);
      OFS_DATA: bus_rdata = sel_ok ? ep_rdata[sel_ix] : '0;
      OFS_CNTL: bus_rdata = sel_ok ? DW'(ep_cnt[sel_ix]) : '0;
      OFS_CNTH: bus_rdata = sel_ok ? DW'(ep_cnt[sel_ix] >> DW) : '0;
      OFS_STAT: bus_rdata = sel_ok ? DW'(ep_ovf[sel_ix]) : '0;
      OFS_CTRL: bus_rdata = sel_ok ? DW'(ep_dir[sel_ix]) : '0;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/usb_epbank_chk.sv
module usb_epbank_chk
  import usb_epbank_pkg::*;
#(
  parameter int NEP       = 7,
  parameter int EP0_DEPTH = 8,
  parameter int EPN_DEPTH = 64,
  parameter int DW        = 8,
  parameter int EW        = 3,
  parameter int CW        = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_rd,
  input logic [AW-1:0]          bus_addr,
  input logic [DW-1:0]          bus_rdata,
  input logic                   rx_good,
  input logic                   rx_bad,
  input logic [EW-1:0]          rx_ep,
  input logic                   tx_done,
  input logic [EW-1:0]          sel_q,
  input logic [NEP-1:0][CW-1:0] ep_ptr,
  input logic [NEP-1:0][CW-1:0] ep_cnt,
  input logic [NEP-1:0]         ep_ovf,
  input logic [NEP-1:0]         ep_dir
);
  // R6: counts only move after a good strobe
  assert_cnt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_good |=> $stable(ep_cnt));

  // R5: high count window is zero in this build
  assert_cnth_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_CNTH) |-> (bus_rdata == '0));

  // R4: read past stored length returns zero
  assert_rd_past_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == OFS_DATA) && (int'(sel_q) < NEP) && !ep_dir[sel_q] &&
     (ep_ptr[sel_q] >= ep_cnt[sel_q])) |-> (bus_rdata == '0));

  for (genvar i = 0; i < NEP; i++) begin : g_chk
    localparam logic [CW-1:0] LIM = CW'((i == 0) ? EP0_DEPTH : EPN_DEPTH);

    // R4: pointers and counts stay within the buffer
    assert_ptr_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_ptr[i] <= LIM) && (ep_cnt[i] <= LIM));

    // R4: overflow is sticky until commit or transmit completion
    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_ovf[i] && !rx_good && !tx_done) |=> ep_ovf[i]);

    // R7: a commit leaves the endpoint pointer at zero
    assert_commit_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_good && !rx_bad && (rx_ep == EW'(i))) |=> (ep_ptr[i] == '0));
  end
endmodule

bind usb_epbank usb_epbank_chk #(
  .NEP(NEP), .EP0_DEPTH(EP0_DEPTH), .EPN_DEPTH(EPN_DEPTH), .DW(DW), .EW(EW), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .rx_good   (rx_good),
  .rx_bad    (rx_bad),
  .rx_ep     (rx_ep),
  .tx_done   (tx_done),
  .sel_q     (sel_q),
  .ep_ptr    (ep_ptr),
  .ep_cnt    (ep_cnt),
  .ep_ovf    (ep_ovf),
  .ep_dir    (ep_dir)
);

// File: tb/usb_epbank_tb.sv
module usb_epbank_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_wr = 1'b0, rx_good = 1'b0, rx_bad = 1'b0;
  logic [2:0] rx_ep = '0;
  logic [7:0] rx_data = '0;
  logic [2:0] tx_ep = '0;
  logic       tx_rd = 1'b0, tx_done = 1'b0;
  logic [7:0] tx_data;
  logic [6:0] tx_len;

  int nchk = 0, nerr = 0;
  bit finished = 1'b0;

  // reference model
  logic [7:0] m_mem [7][64];
  int m_ptr [7], m_cnt [7], m_ovf [7], m_dir [7];
  int m_sel, m_txidx;

  always #5 clk = ~clk;

  usb_epbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_wr(rx_wr), .rx_ep(rx_ep),
    .rx_data(rx_data), .rx_good(rx_good), .rx_bad(rx_bad), .tx_ep(tx_ep),
    .tx_rd(tx_rd), .tx_done(tx_done), .tx_data(tx_data), .tx_len(tx_len)
  );

  function automatic int ep_size(int e);
    return (e == 0) ? 8 : 64;
  endfunction

  function automatic int exp_reg(int a);
    bit v = (m_sel < 7);
    case (a)
      0: return m_sel;
      1: return (v && m_dir[m_sel] == 0 && m_ptr[m_sel] < m_cnt[m_sel]) ?
                int'(m_mem[m_sel][m_ptr[m_sel]]) : 0;
      2: return v ? m_cnt[m_sel] : 0;
      4: return v ? m_ovf[m_sel] : 0;
      5: return v ? m_dir[m_sel] : 0;
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_read(int a, string tag);
    int e;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 3'(a);
    #1;
    e = exp_reg(a);
    chk(int'(bus_rdata) == e, tag, int'(bus_rdata), e);
    @(posedge clk);
    if (a == 1 && m_sel < 7 && m_dir[m_sel] == 0 && m_ptr[m_sel] < m_cnt[m_sel])
      m_ptr[m_sel]++;
    #1 bus_rd = 1'b0;
  endtask

  task automatic bus_write(int a, int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(posedge clk);
    if (a == 0) m_sel = d & 7;
    else if (a == 5 && m_sel < 7) m_dir[m_sel] = d & 1;
    else if (a == 1 && m_sel < 7 && m_dir[m_sel] == 1) begin
      if (m_ptr[m_sel] < ep_size(m_sel)) begin
        m_mem[m_sel][m_ptr[m_sel]] = 8'(d);
        m_ptr[m_sel]++;
      end else m_ovf[m_sel] = 1;
    end
    #1 bus_wr = 1'b0;
  endtask

  task automatic rx_packet(int e, int len, bit good);
    int fill = 0;
    for (int b = 0; b < len; b++) begin
      @(negedge clk);
      rx_wr = 1'b1; rx_ep = 3'(e); rx_data = 8'($urandom);
      @(posedge clk);
      if (fill < ep_size(e)) begin
        m_mem[e][fill] = rx_data;
        fill++;
      end
      #1 rx_wr = 1'b0;
    end
    @(negedge clk);
    rx_ep = 3'(e); rx_good = good; rx_bad = !good;
    @(posedge clk);
    if (good) begin
      m_cnt[e] = fill; m_ptr[e] = 0; m_ovf[e] = 0;
    end
    #1 rx_good = 1'b0; rx_bad = 1'b0;
  endtask

  task automatic tx_check(int e, int n, string tag);
    int ex;
    @(negedge clk);
    tx_ep = 3'(e);
    #1 chk(int'(tx_len) == m_ptr[e], {tag, " len"}, int'(tx_len), m_ptr[e]);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
      ex = (m_txidx < ep_size(e)) ? int'(m_mem[e][m_txidx]) : 0;
      chk(int'(tx_data) == ex, {tag, " data"}, int'(tx_data), ex);
      tx_rd = 1'b1;
      @(posedge clk);
      if (m_txidx < 64) m_txidx++;
      #1 tx_rd = 1'b0;
    end
    @(negedge clk);
    tx_done = 1'b1;
    @(posedge clk);
    m_ptr[e] = 0; m_ovf[e] = 0; m_txidx = 0;
    #1 tx_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int e = 0; e < 7; e++) begin
      m_ptr[e] = 0; m_cnt[e] = 0; m_ovf[e] = 0; m_dir[e] = 0;
      for (int j = 0; j < 64; j++) m_mem[e][j] = '0;
    end
    m_sel = 0; m_txidx = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R11: reset state
    bus_read(0, "R11 sel");
    bus_read(2, "R11 cnt");
    bus_read(4, "R11 stat");
    bus_read(5, "R11 ctrl");
    bus_read(1, "R11 data");

    // R7, R5, R2, R6, R8
    rx_packet(1, 5, 1'b1);
    bus_write(0, 1);
    bus_read(2, "R7 committed count");
    bus_read(3, "R5 count high");
    bus_read(1, "R2 data0");
    bus_read(1, "R2 data1");
    bus_read(1, "R2 data2");
    bus_read(2, "R6 count after reads");
    bus_write(0, 2);
    bus_read(1, "R4 empty ep read");
    bus_write(0, 1);
    bus_read(1, "R8 resume data3");
    bus_read(1, "R8 resume data4");
    bus_read(1, "R4 read past end");
    bus_read(1, "R4 read past end again");

    // R7 bad packet discarded
    rx_packet(1, 3, 1'b0);
    bus_read(2, "R7 bad keeps count");
    bus_read(1, "R7 bad keeps pointer");

    // R10, R3, R9, R6: IN endpoint 3
    bus_write(0, 3);
    bus_write(5, 1);
    bus_read(5, "R10 ctrl dir");
    for (int k = 0; k < 4; k++) bus_write(1, 8'h30 + k);
    bus_read(1, "R10 read on IN ep");
    bus_read(2, "R6 count after writes");
    tx_check(3, 4, "R3 R9 ep3");
    tx_check(3, 0, "R9 after done");

    // R4 overflow on ep0
    bus_write(0, 0);
    bus_write(5, 1);
    for (int k = 0; k < 10; k++) bus_write(1, 8'hA0 + k);
    bus_read(4, "R4 overflow flag");
    tx_check(0, 9, "R4 ep0 tx");
    bus_read(4, "R9 overflow cleared");

    // R1 invalid select
    bus_write(0, 7);
    bus_read(0, "R1 sel readback");
    bus_write(1, 8'h55);
    bus_read(1, "R1 data invalid");
    bus_read(2, "R1 cnt invalid");
    tx_check(0, 0, "R1 no ep change");

    // R10 write to OUT endpoint ignored
    bus_write(0, 1);
    bus_write(1, 8'h77);
    tx_check(1, 0, "R10 write ignored");

    // R7 oversize packet
    rx_packet(0, 12, 1'b1);
    bus_write(0, 0);
    bus_write(5, 0);
    bus_read(2, "R7 oversize count");
    for (int k = 0; k < 9; k++) bus_read(1, "R7 oversize data");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 7);
      case (op)
        0: bus_write(0, $urandom_range(0, 7));
        1: bus_write(5, $urandom_range(0, 1));
        2, 3: bus_read(1, "R2 random data");
        4: bus_write(1, $urandom_range(0, 255));
        5: rx_packet($urandom_range(0, 6), $urandom_range(0, 70), $urandom_range(0, 3) != 0);
        6: tx_check($urandom_range(0, 6), $urandom_range(0, 10), "R9 random tx");
        default: begin
          bus_read(2, "R5 random count");
          bus_read(4, "R4 random status");
          bus_read(3, "R5 random high");
        end
      endcase
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule